// File: doc/BRIEF.md
# Smooth Real-Time-Clock Rate Trimmer

This block trims the average rate of a 32.768 kHz real-time-clock source. It does not touch the clock itself. For every raw clock cycle it reports how many increments the downstream prescaler chain should take: zero when the pulse is swallowed, one normally, and two when an extra pulse is inserted. Swallowed pulses are spread evenly over a calibration window. The slot index of each candidate position is bit-reversed and compared with the programmed swallow count. The window lasts 2^CYC_W raw cycles, which is 32 s with the default of 20.

Software can shorten the window to a half (16 s) or a quarter (8 s). The shorter window gives a faster measurement at a coarser resolution, so the lowest one or two bits of the swallow count are ignored. The insert bit adds 2^9 pulses per 32 s window, scaled down in the same ratio for the shorter windows.

Writes made during initialisation take effect at once. Writes made while the clock runs are held in a shadow and raise a pending flag. The held values become active on the next prescaler tick, and the window counter restarts from zero at that moment.

Top module: `rtc_smooth_trim`

## Requirements
- R1: After reset the pending flag is 0, and the active settings are swallow count 0, insert off and 32 s window, so `adv_o` is 1 on every cycle.
- R2: In the 32 s window, the sum of `adv_o` over one window of 2^CYC_W cycles is 2^CYC_W minus the swallow count, plus 2^9 when the insert bit is set.
- R3: With the insert bit set, `adv_o` is 2 on exactly 2^9 cycles of each 32 s window, and never otherwise.
- R4: Swallowed cycles (`adv_o`==0) are spread evenly. Over a 32 s window, the numbers falling in the first and second halves differ by at most one, and a swallow falls only on a cycle whose count is a multiple of 2^(CYC_W-9).
- R5: With the 16 s bit set and the 8 s bit clear, the window is 2^(CYC_W-1) cycles. Each window sums to 2^(CYC_W-1) − (count>>1) + 256·insert, so count bit 0 has no effect.
- R6: With the 8 s bit set (whatever the 16 s bit is), the window is 2^(CYC_W-2) cycles. Each window sums to 2^(CYC_W-2) − (count>>2) + 128·insert, so count bits 1:0 have no effect.
- R7: A write with `init_mode_i`=0 and pending=0 sets pending on the next cycle, and the old settings stay in use. On the first clock edge that samples `tick_i`=1, the new settings become active, the window restarts at count 0 and pending clears. This is well within three ticks.
- R8: A write with `init_mode_i`=0 while pending=1 is ignored. The values from the earlier accepted write are the ones committed.
- R9: A write with `init_mode_i`=1 becomes active at the next clock edge, restarts the window at count 0, and leaves pending at 0.
- R10: `adv_o` encodes the prescaler increments for the current raw cycle as 0 (swallowed), 1 (normal) or 2 (inserted), and is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Raw real-time-clock source; every cycle is one candidate pulse |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Prescaler tick strobe; commits pending settings |
| init_mode_i | input | 1 | Initialisation mode; writes bypass the pending mechanism |
| wr_en_i | input | 1 | Write strobe for the settings below |
| wr_count_i | input | 9 | Number of pulses to swallow per 32 s window |
| wr_insert_i | input | 1 | Insert 2^9 extra pulses per 32 s window |
| wr_half_i | input | 1 | Select the 16 s window |
| wr_quarter_i | input | 1 | Select the 8 s window; takes precedence over the 16 s bit |
| adv_o | output | 2 | Prescaler increments for this cycle: 0, 1 or 2 |
| pend_o | output | 1 | Recalibration pending: a run-mode write awaits the next tick |

## Verification
The hardest situation to reach from the ports is a second run-mode write that lands while an earlier one is still pending. The rejected values must leave no trace in the settings that are later committed.

The bench makes an accepted write and holds the tick low for several cycles. It then writes a very different swallow count, commits with a single tick and sums `adv_o` over a full window. The total must match the first write only.

Window restart is checked by measuring sums that start at the exact cycle of commit. The even spread of swallowed pulses is checked by comparing swallow counts in the two halves of a window.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int TRIM_CNT_W = 9;

  // window selection; the encoded value is the right-shift of the window length
  typedef enum logic [1:0] {
    WIN_FULL    = 2'd0,
    WIN_HALF    = 2'd1,
    WIN_QUARTER = 2'd2
  } trim_win_e;

  typedef struct packed {
    logic [TRIM_CNT_W-1:0] count;
    logic                  insert;
    logic                  half;
    logic                  quarter;
  } trim_cfg_t;

  function automatic trim_win_e win_of(input trim_cfg_t c);
    if (c.quarter)   return WIN_QUARTER;
    else if (c.half) return WIN_HALF;
    return WIN_FULL;
  endfunction

  function automatic logic [TRIM_CNT_W-1:0] bit_reverse(input logic [TRIM_CNT_W-1:0] v);
    logic [TRIM_CNT_W-1:0] r;
    for (int i = 0; i < TRIM_CNT_W; i++) r[i] = v[TRIM_CNT_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
  import rtc_trim_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      init_mode,
  input  logic      wr_en,
  input  trim_cfg_t wr_cfg,
  output trim_cfg_t act_cfg,
  output logic      pend,
  output logic      restart
);
  trim_cfg_t shadow_q, shadow_d, act_q, act_d;
  logic      pend_q, pend_d;
  logic      take_init, take_run, commit;

  always_comb begin
    take_init = wr_en && init_mode;
    take_run  = wr_en && !init_mode && !pend_q;
    commit    = pend_q && tick;
    shadow_d  = shadow_q;
    act_d     = act_q;
    pend_d    = pend_q;
    if (take_run) begin
      shadow_d = wr_cfg;
      pend_d   = 1'b1;
    end
    if (commit) begin
      act_d  = shadow_q;
      pend_d = 1'b0;
    end
    if (take_init) begin
      act_d  = wr_cfg;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      act_q    <= act_d;
      pend_q   <= pend_d;
    end
  end

  assign act_cfg = act_q;
  assign pend    = pend_q;
  assign restart = commit || take_init;

  // R7: an accepted run-mode write raises the pending flag
  assert_wr_sets_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !init_mode && !pend_q) |=> pend_q);
  // R7: a tick while pending clears the flag
  assert_tick_clears_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tick) |=> !pend_q);
  // R8: while pending and without tick or init, nothing changes
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !tick && !init_mode) |=> (pend_q && $stable(act_q)));
  // R9: init-mode writes never leave a pending flag
  assert_init_no_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && init_mode) |=> !pend_q);
endmodule

// File: rtl/rtc_trim_counter.sv
module rtc_trim_counter
  import rtc_trim_pkg::*;
#(
  parameter int CYC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  trim_win_e        win,
  output logic [CYC_W-1:0] cnt
);
  localparam logic [CYC_W-1:0] ALL_ONES = '1;

  logic [CYC_W-1:0] cnt_q, cnt_d, last;
  logic             cnt_en;

  always_comb begin
    last   = ALL_ONES >> win;
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (restart)            cnt_d = '0;
    else if (cnt_en)        cnt_d = (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R5: the count stays inside the selected window
  assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
  // R7: a commit restarts the window from zero
  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_trim_gate.sv
module rtc_trim_gate
  import rtc_trim_pkg::*;
#(
  parameter int CYC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] cnt,
  input  trim_cfg_t        cfg,
  input  trim_win_e        win,
  output logic [1:0]       adv
);
  localparam int SUB_W = CYC_W - TRIM_CNT_W;
  localparam logic [SUB_W-1:0] INS_POS = SUB_W'(1) << (SUB_W - 1);

  logic                  slot, swallow, insert_hit;
  logic [TRIM_CNT_W-1:0] idx, rev, keep, count_eff;

  always_comb begin
    slot       = (cnt[SUB_W-1:0] == '0);
    idx        = cnt[CYC_W-1:SUB_W];
    rev        = bit_reverse(idx);
    keep       = {TRIM_CNT_W{1'b1}} << win;
    count_eff  = cfg.count & keep;
    swallow    = slot && (rev < count_eff);
    insert_hit = cfg.insert && (cnt[SUB_W-1:0] == INS_POS);
    adv        = 2'd1 - {1'b0, swallow} + {1'b0, insert_hit};
  end

  // R4: swallowed cycles fall only on slot boundaries
  assert_swallow_on_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv == 2'd0) |-> (cnt[SUB_W-1:0] == '0));
  // R3: a double increment requires the insert bit
  assert_double_needs_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv == 2'd2) |-> cfg.insert);
  // R10: the encoding never reaches 3
  assert_adv_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adv != 2'd3);
endmodule

// File: rtl/rtc_smooth_trim.sv
module rtc_smooth_trim
  import rtc_trim_pkg::*;
#(
  parameter int CYC_W = 20
) (
  input  logic                  clk_rtc,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  init_mode_i,
  input  logic                  wr_en_i,
  input  logic [TRIM_CNT_W-1:0] wr_count_i,
  input  logic                  wr_insert_i,
  input  logic                  wr_half_i,
  input  logic                  wr_quarter_i,
  output logic [1:0]            adv_o,
  output logic                  pend_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  trim_cfg_t        wr_cfg, act_cfg;
  trim_win_e        win;
  logic             restart;
  logic [CYC_W-1:0] cnt;

  always_ff @(posedge clk_rtc or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    wr_cfg.count   = wr_count_i;
    wr_cfg.insert  = wr_insert_i;
    wr_cfg.half    = wr_half_i;
    wr_cfg.quarter = wr_quarter_i;
    win            = win_of(act_cfg);
  end

  rtc_trim_regs regs_i (
    .clk       (clk_rtc),
    .rst_n     (rst_int_n),
    .tick      (tick_i),
    .init_mode (init_mode_i),
    .wr_en     (wr_en_i),
    .wr_cfg    (wr_cfg),
    .act_cfg   (act_cfg),
    .pend      (pend_o),
    .restart   (restart)
  );

  rtc_trim_counter #(.CYC_W(CYC_W)) counter_i (
    .clk     (clk_rtc),
    .rst_n   (rst_int_n),
    .restart (restart),
    .win     (win),
    .cnt     (cnt)
  );

  rtc_trim_gate #(.CYC_W(CYC_W)) gate_i (
    .clk   (clk_rtc),
    .rst_n (rst_int_n),
    .cnt   (cnt),
    .cfg   (act_cfg),
    .win   (win),
    .adv   (adv_o)
  );

  // R1: while the internal reset is held, no pulse is swallowed or inserted
  assert_reset_plain_R1: assert property (@(posedge clk_rtc)
    (!rst_int_n) |-> (adv_o == 2'd1 && !pend_o));
endmodule

// File: tb/rtc_smooth_trim_tb.sv
module rtc_smooth_trim_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CYC_W      = 12;
  localparam int WIN_FULL_N = 1 << CYC_W;

  logic       clk_rtc = 1'b0;
  logic       rst_n;
  logic       tick_i, init_mode_i, wr_en_i;
  logic [8:0] wr_count_i;
  logic       wr_insert_i, wr_half_i, wr_quarter_i;
  logic [1:0] adv_o;
  logic       pend_o;

  int tests = 0;
  int fails = 0;
  int sum_adv, n_zero_a, n_zero_b, n_two, n_three;

  always #(CLK_PERIOD/2) clk_rtc = ~clk_rtc;

  rtc_smooth_trim #(.CYC_W(CYC_W)) dut_i (
    .clk_rtc(clk_rtc), .rst_n(rst_n), .tick_i(tick_i), .init_mode_i(init_mode_i),
    .wr_en_i(wr_en_i), .wr_count_i(wr_count_i), .wr_insert_i(wr_insert_i),
    .wr_half_i(wr_half_i), .wr_quarter_i(wr_quarter_i), .adv_o(adv_o), .pend_o(pend_o));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int cnt, input bit ins, input bit half, input bit quarter);
    wr_count_i = 9'(cnt); wr_insert_i = ins; wr_half_i = half; wr_quarter_i = quarter;
  endtask

  task automatic write_init(input int cnt, input bit ins, input bit half, input bit quarter);
    set_cfg(cnt, ins, half, quarter);
    init_mode_i = 1'b1; wr_en_i = 1'b1;
    @(negedge clk_rtc);
    wr_en_i = 1'b0; init_mode_i = 1'b0;
  endtask

  task automatic write_run(input int cnt, input bit ins, input bit half, input bit quarter);
    set_cfg(cnt, ins, half, quarter);
    wr_en_i = 1'b1;
    @(negedge clk_rtc);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_tick();
    tick_i = 1'b1;
    @(negedge clk_rtc);
    tick_i = 1'b0;
  endtask

  task automatic measure(input int len);
    sum_adv = 0; n_zero_a = 0; n_zero_b = 0; n_two = 0; n_three = 0;
    for (int i = 0; i < len; i++) begin
      sum_adv += int'(adv_o);
      if (adv_o == 2'd0) begin
        if (i < len/2) n_zero_a++; else n_zero_b++;
      end
      if (adv_o == 2'd2) n_two++;
      if (adv_o == 2'd3) n_three++;
      @(negedge clk_rtc);
    end
  endtask

  task automatic t_reset();
    int bad = 0;
    check(pend_o == 1'b0, "R1 pend after reset", pend_o, 0);
    for (int i = 0; i < 16; i++) begin
      if (adv_o != 2'd1) bad++;
      @(negedge clk_rtc);
    end
    check(bad == 0, "R1 adv stays 1 after reset", bad, 0);
  endtask

  task automatic t_full_swallow();
    write_init(100, 1'b0, 1'b0, 1'b0);
    check(pend_o == 1'b0, "R9 init write leaves pend clear", pend_o, 0);
    measure(WIN_FULL_N);
    check(sum_adv == WIN_FULL_N - 100, "R2 full window sum", sum_adv, WIN_FULL_N - 100);
    check((n_zero_a - n_zero_b <= 1) && (n_zero_b - n_zero_a <= 1),
          "R4 halves balanced (100)", n_zero_a, n_zero_b);
    check(n_three == 0, "R10 no code 3", n_three, 0);
    write_init(256, 1'b0, 1'b0, 1'b0);
    measure(WIN_FULL_N);
    check(n_zero_a == 128 && n_zero_b == 128, "R4 halves for 256", n_zero_a, 128);
    check(sum_adv == WIN_FULL_N - 256, "R2 full window sum 256", sum_adv, WIN_FULL_N - 256);
  endtask

  task automatic t_insert();
    write_init(37, 1'b1, 1'b0, 1'b0);
    measure(WIN_FULL_N);
    check(sum_adv == WIN_FULL_N + 512 - 37, "R2 sum with insert", sum_adv, WIN_FULL_N + 512 - 37);
    check(n_two == 512, "R3 inserted count", n_two, 512);
    check(n_three == 0, "R10 no code 3 with insert", n_three, 0);
  endtask

  task automatic t_half();
    int exp = 2 * ((WIN_FULL_N/2) - (101 >> 1));
    write_init(101, 1'b0, 1'b1, 1'b0);
    measure(WIN_FULL_N);
    check(sum_adv == exp, "R5 two half windows, bit0 ignored", sum_adv, exp);
    write_init(100, 1'b1, 1'b1, 1'b0);
    measure(WIN_FULL_N/2);
    check(sum_adv == WIN_FULL_N/2 - 50 + 256, "R5 half window with insert",
          sum_adv, WIN_FULL_N/2 - 50 + 256);
  endtask

  task automatic t_quarter();
    int exp = WIN_FULL_N/4 + 128 - (511 >> 2);
    write_init(511, 1'b1, 1'b1, 1'b1);
    measure(WIN_FULL_N/4);
    check(sum_adv == exp, "R6 quarter window, both bits set", sum_adv, exp);
    write_init(3, 1'b0, 1'b0, 1'b1);
    measure(WIN_FULL_N/2);
    check(sum_adv == WIN_FULL_N/2, "R6 low count bits ignored", sum_adv, WIN_FULL_N/2);
  endtask

  task automatic t_run_write();
    int bad = 0;
    write_init(0, 1'b0, 1'b0, 1'b0);
    write_run(50, 1'b0, 1'b0, 1'b0);
    check(pend_o == 1'b1, "R7 pend set after run write", pend_o, 1);
    for (int i = 0; i < 5; i++) begin
      if (pend_o != 1'b1 || adv_o != 2'd1) bad++;
      @(negedge clk_rtc);
    end
    check(bad == 0, "R7 old settings kept until tick", bad, 0);
    pulse_tick();
    check(pend_o == 1'b0, "R7 pend cleared by tick", pend_o, 0);
    check(adv_o == 2'd0, "R7 new settings from count 0", adv_o, 0);
    measure(WIN_FULL_N);
    check(sum_adv == WIN_FULL_N - 50, "R7 committed window sum", sum_adv, WIN_FULL_N - 50);
  endtask

  task automatic t_busy_write();
    write_run(50, 1'b0, 1'b0, 1'b0);
    write_run(300, 1'b1, 1'b0, 1'b1);
    check(pend_o == 1'b1, "R8 pend stays after ignored write", pend_o, 1);
    pulse_tick();
    check(pend_o == 1'b0, "R8 pend cleared", pend_o, 0);
    measure(WIN_FULL_N);
    check(sum_adv == WIN_FULL_N - 50, "R8 second write ignored", sum_adv, WIN_FULL_N - 50);
  endtask

  task automatic t_init_write();
    write_init(7, 1'b0, 1'b0, 1'b0);
    check(pend_o == 1'b0, "R9 no pend on init write", pend_o, 0);
    check(adv_o == 2'd0, "R9 active at next edge from count 0", adv_o, 0);
    measure(WIN_FULL_N);
    check(sum_adv == WIN_FULL_N - 7, "R9 init window sum", sum_adv, WIN_FULL_N - 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk_rtc);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; init_mode_i = 1'b0; wr_en_i = 1'b0;
    set_cfg(0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk_rtc);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_rtc);
    t_reset();
    t_full_swallow();
    t_insert();
    t_half();
    t_quarter();
    t_run_write();
    t_busy_write();
    t_init_write();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule